// File: doc/BRIEF.md
# Call/Interrupt Return Stack Controller

This block keeps the return stack of a small 8-bit processor inside the shared data RAM. A subroutine call or an accepted interrupt makes it save the current 13-bit program counter together with the three status flags (carry, zero, sign). A return makes it fetch the newest saved level back. The kind of return controls the flags. An interrupt return asks the core to reload them. A plain subroutine return hands back only the program counter, and the core keeps its present flags.

Each saved level takes two bytes of RAM. The controller owns one port of the RAM for the two cycles of every push or pop. It raises a busy signal for that time. The stack pointer is exposed so that software can read it as an input register. The pointer always names the first free byte. It moves downward from the top of RAM and wraps modulo the RAM size. Nothing stops the stack from overwriting user data, so software must keep the two areas apart.

Top module: `retstk_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets `sp_o` to 255 and clears `busy_o`, `rest_valid_o`, `flag_load_o`, `rest_pc_o` and `rest_flags_o`.
- R2: A push is started by `call_i` or `irq_i` while idle. In the first busy cycle it writes PC[7:0] at address `sp_o`. In the second busy cycle it writes a byte at `sp_o`-1 that holds flags in bits 7:5 and PC[12:8] in bits 4:0.
- R3: `sp_o` always holds the first free byte address. Each completed push lowers it by 2 and each completed pop raises it by 2, modulo 256. After 128 pushes from reset it is back at 255.
- R4: A pop is started by `ret_i` or `reti_i` while idle. In the first busy cycle it reads the high byte at `sp_o`+1. In the second busy cycle it reads the low byte at the next address up. RAM read data is taken in the same cycle as the address.
- R5: One cycle after the second pop cycle, `rest_valid_o` is high for exactly one cycle. In that cycle `rest_pc_o` and `rest_flags_o` show the program counter and flags of the most recently pushed level.
- R6: `flag_load_o` is 1 together with `rest_valid_o` for an interrupt return and 0 for a subroutine return.
- R7: When a push strobe and a return strobe arrive in the same idle cycle, only the push is performed.
- R8: `busy_o` is high for exactly the two cycles after an accepted strobe. Strobes that arrive while `busy_o` is high are ignored. They cause no RAM access, no pointer change and no restore pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| call_i | input | 1 | Subroutine call strobe (push) |
| irq_i | input | 1 | Accepted interrupt strobe (push) |
| ret_i | input | 1 | Subroutine return strobe (pop, flags kept) |
| reti_i | input | 1 | Interrupt return strobe (pop, flags reloaded) |
| pc_i | input | 13 | Program counter to save |
| flags_i | input | 3 | Flags to save |
| ram_addr_o | output | 8 | RAM byte address |
| ram_we_o | output | 1 | RAM write enable |
| ram_re_o | output | 1 | RAM read strobe |
| ram_wdata_o | output | 8 | RAM write data |
| ram_rdata_i | input | 8 | RAM read data, same-cycle |
| rest_pc_o | output | 13 | Restored program counter |
| rest_flags_o | output | 3 | Restored flags |
| rest_valid_o | output | 1 | One-cycle pulse: restored values valid |
| flag_load_o | output | 1 | Core should reload flags from `rest_flags_o` |
| sp_o | output | 8 | Current stack pointer |
| busy_o | output | 1 | Push or pop in progress |

## Verification
The bench builds the block with its default parameters: an 8-bit address, a 13-bit program counter, three flags and a downward-growing stack. With these values the high byte is filled exactly by flags and PC bits, so every bit of the byte format can be checked directly in the RAM model. The 256-byte space holds 128 levels, so a 129-level push sequence is short enough to reach pointer wrap and the overwrite of the oldest level. A scoreboard queue then matches each restore pulse against the level the bench expects on top of the stack.

// File: rtl/retstk_pkg.sv
package retstk_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PUSH_LO,
      ST_PUSH_HI,
      ST_POP_HI,
      ST_POP_LO
   } stk_state_e;

endpackage

// File: rtl/retstk_ptr.sv
module retstk_ptr #(
   parameter int ADDR_W    = 8,
   parameter bit GROW_DOWN = 1'b1,
   parameter logic [ADDR_W-1:0] RESET_SP = '1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              step_fwd,
   input  logic              step_back,
   output logic [ADDR_W-1:0] sp_o,
   output logic [ADDR_W-1:0] peek_o
);
   localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

   logic [ADDR_W-1:0] sp_q;
   logic [ADDR_W-1:0] toward_free;
   logic [ADDR_W-1:0] toward_used;

   generate
      if (GROW_DOWN) begin : g_down
         assign toward_free = sp_q - ONE;
         assign toward_used = sp_q + ONE;
      end else begin : g_up
         assign toward_free = sp_q + ONE;
         assign toward_used = sp_q - ONE;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)            sp_q <= RESET_SP;
      else if (step_fwd)  sp_q <= toward_free;
      else if (step_back) sp_q <= toward_used;
   end

   assign sp_o   = sp_q;
   assign peek_o = toward_used;
endmodule

// File: rtl/retstk_pack.sv
module retstk_pack #(
   parameter int PC_W   = 13,
   parameter int FLAG_W = 3,
   parameter int DATA_W = 8
) (
   input  logic [PC_W-1:0]   pc_i,
   input  logic [FLAG_W-1:0] flags_i,
   output logic [DATA_W-1:0] lo_o,
   output logic [DATA_W-1:0] hi_o,
   input  logic [DATA_W-1:0] lo_i,
   input  logic [DATA_W-1:0] hi_i,
   output logic [PC_W-1:0]   pc_o,
   output logic [FLAG_W-1:0] flags_o
);
   localparam int PC_HI_W = PC_W - DATA_W;
   localparam int FLAG_LSB = DATA_W - FLAG_W;

   assign lo_o = pc_i[DATA_W-1:0];

   generate
      for (genvar b = 0; b < DATA_W; b++) begin : g_hi
         if (b < PC_HI_W) begin : g_pc
            assign hi_o[b] = pc_i[DATA_W+b];
         end else if (b >= FLAG_LSB) begin : g_fl
            assign hi_o[b] = flags_i[b-FLAG_LSB];
         end else begin : g_pad
            assign hi_o[b] = 1'b0;
         end
      end
   endgenerate

   assign pc_o    = {hi_i[PC_HI_W-1:0], lo_i};
   assign flags_o = hi_i[DATA_W-1 -: FLAG_W];
endmodule

// File: rtl/retstk_seq.sv
module retstk_seq
   import retstk_pkg::*;
#(
   parameter int PC_W   = 13,
   parameter int FLAG_W = 3,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              push_req,
   input  logic              pop_req,
   input  logic              reti_req,
   input  logic [PC_W-1:0]   pc_i,
   input  logic [FLAG_W-1:0] flags_i,
   input  logic [DATA_W-1:0] rdata_i,
   input  logic [PC_W-1:0]   unp_pc_i,
   input  logic [FLAG_W-1:0] unp_flags_i,
   output logic [PC_W-1:0]   pc_q,
   output logic [FLAG_W-1:0] flags_q,
   output logic [DATA_W-1:0] hi_q,
   output logic              wr_en,
   output logic              rd_en,
   output logic              wr_hi,
   output logic              busy,
   output logic [PC_W-1:0]   rest_pc,
   output logic [FLAG_W-1:0] rest_flags,
   output logic              rest_valid,
   output logic              flag_load
);
   stk_state_e state;
   logic       reti_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         state      <= ST_IDLE;
         pc_q       <= '0;
         flags_q    <= '0;
         hi_q       <= '0;
         reti_q     <= 1'b0;
         rest_pc    <= '0;
         rest_flags <= '0;
         rest_valid <= 1'b0;
         flag_load  <= 1'b0;
      end else begin
         rest_valid <= 1'b0;
         flag_load  <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (push_req) begin
                  pc_q    <= pc_i;
                  flags_q <= flags_i;
                  state   <= ST_PUSH_LO;
               end else if (pop_req) begin
                  reti_q <= reti_req;
                  state  <= ST_POP_HI;
               end
            end
            ST_PUSH_LO: state <= ST_PUSH_HI;
            ST_PUSH_HI: state <= ST_IDLE;
            ST_POP_HI: begin
               hi_q  <= rdata_i;
               state <= ST_POP_LO;
            end
            ST_POP_LO: begin
               rest_pc    <= unp_pc_i;
               rest_flags <= unp_flags_i;
               rest_valid <= 1'b1;
               flag_load  <= reti_q;
               state      <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign wr_en = (state == ST_PUSH_LO) || (state == ST_PUSH_HI);
   assign wr_hi = (state == ST_PUSH_HI);
   assign rd_en = (state == ST_POP_HI) || (state == ST_POP_LO);
   assign busy  = (state != ST_IDLE);
endmodule

// File: rtl/retstk_ctrl.sv
module retstk_ctrl #(
   parameter int ADDR_W    = 8,
   parameter int PC_W      = 13,
   parameter int FLAG_W    = 3,
   parameter int DATA_W    = 8,
   parameter bit GROW_DOWN = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              call_i,
   input  logic              irq_i,
   input  logic              ret_i,
   input  logic              reti_i,
   input  logic [PC_W-1:0]   pc_i,
   input  logic [FLAG_W-1:0] flags_i,
   output logic [ADDR_W-1:0] ram_addr_o,
   output logic              ram_we_o,
   output logic              ram_re_o,
   output logic [DATA_W-1:0] ram_wdata_o,
   input  logic [DATA_W-1:0] ram_rdata_i,
   output logic [PC_W-1:0]   rest_pc_o,
   output logic [FLAG_W-1:0] rest_flags_o,
   output logic              rest_valid_o,
   output logic              flag_load_o,
   output logic [ADDR_W-1:0] sp_o,
   output logic              busy_o
);
   localparam logic [ADDR_W-1:0] RESET_SP = GROW_DOWN ? {ADDR_W{1'b1}} : '0;

   generate
      if (PC_W <= DATA_W || PC_W - DATA_W + FLAG_W > DATA_W) begin : g_bad_fmt
         $error("retstk_ctrl: PC high bits and flags must fit one data byte");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("retstk_ctrl: address width too small for a two-byte level");
      end
   endgenerate

   logic [PC_W-1:0]   pc_q, unp_pc;
   logic [FLAG_W-1:0] flags_q, unp_flags;
   logic [DATA_W-1:0] hi_q, lo_byte, hi_byte;
   logic [ADDR_W-1:0] peek;
   logic              wr_en, rd_en, wr_hi;

   retstk_seq #(.PC_W(PC_W), .FLAG_W(FLAG_W), .DATA_W(DATA_W)) u_seq (
      .clk        (clk),
      .rst        (rst),
      .push_req   (call_i | irq_i),
      .pop_req    (ret_i | reti_i),
      .reti_req   (reti_i),
      .pc_i       (pc_i),
      .flags_i    (flags_i),
      .rdata_i    (ram_rdata_i),
      .unp_pc_i   (unp_pc),
      .unp_flags_i(unp_flags),
      .pc_q       (pc_q),
      .flags_q    (flags_q),
      .hi_q       (hi_q),
      .wr_en      (wr_en),
      .rd_en      (rd_en),
      .wr_hi      (wr_hi),
      .busy       (busy_o),
      .rest_pc    (rest_pc_o),
      .rest_flags (rest_flags_o),
      .rest_valid (rest_valid_o),
      .flag_load  (flag_load_o)
   );

   retstk_ptr #(.ADDR_W(ADDR_W), .GROW_DOWN(GROW_DOWN), .RESET_SP(RESET_SP)) u_ptr (
      .clk      (clk),
      .rst      (rst),
      .step_fwd (wr_en),
      .step_back(rd_en),
      .sp_o     (sp_o),
      .peek_o   (peek)
   );

   retstk_pack #(.PC_W(PC_W), .FLAG_W(FLAG_W), .DATA_W(DATA_W)) u_pack (
      .pc_i   (pc_q),
      .flags_i(flags_q),
      .lo_o   (lo_byte),
      .hi_o   (hi_byte),
      .lo_i   (ram_rdata_i),
      .hi_i   (hi_q),
      .pc_o   (unp_pc),
      .flags_o(unp_flags)
   );

   assign ram_we_o    = wr_en;
   assign ram_re_o    = rd_en;
   assign ram_addr_o  = wr_en ? sp_o : peek;
   assign ram_wdata_o = wr_hi ? hi_byte : lo_byte;
endmodule

// File: rtl/retstk_chk.sv
module retstk_chk #(
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst,
   input logic [ADDR_W-1:0] sp_o,
   input logic [ADDR_W-1:0] ram_addr_o,
   input logic              ram_we_o,
   input logic              ram_re_o,
   input logic              rest_valid_o,
   input logic              flag_load_o,
   input logic              busy_o
);
   // R1
   reset_state_chk: assert property (@(posedge clk)
      rst |=> (sp_o == {ADDR_W{1'b1}}) && !busy_o && !rest_valid_o && !flag_load_o);

   // R2
   push_second_byte_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(ram_we_o) |=> ram_we_o && (ram_addr_o == ADDR_W'($past(ram_addr_o) - 1'b1)));

   // R3
   push_leaves_free_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(ram_we_o) |-> sp_o == ADDR_W'($past(ram_addr_o) - 1'b1));

   // R4
   pop_second_byte_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(ram_re_o) |=> ram_re_o && (ram_addr_o == ADDR_W'($past(ram_addr_o) + 1'b1)));

   // R5
   valid_single_chk: assert property (@(posedge clk) disable iff (rst)
      rest_valid_o |=> !rest_valid_o);

   // R5
   valid_after_read_chk: assert property (@(posedge clk) disable iff (rst)
      rest_valid_o |-> $past(ram_re_o) && !busy_o);

   // R6
   flag_load_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
      flag_load_o |-> rest_valid_o);

   // R8
   busy_two_cycles_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(busy_o) |=> busy_o ##1 !busy_o);

   // R8
   idle_sp_still_chk: assert property (@(posedge clk) disable iff (rst)
      !busy_o |=> $stable(sp_o));

   // R7
   no_rw_overlap_chk: assert property (@(posedge clk) disable iff (rst)
      !(ram_we_o && ram_re_o));
endmodule

bind retstk_ctrl retstk_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .sp_o        (sp_o),
   .ram_addr_o  (ram_addr_o),
   .ram_we_o    (ram_we_o),
   .ram_re_o    (ram_re_o),
   .rest_valid_o(rest_valid_o),
   .flag_load_o (flag_load_o),
   .busy_o      (busy_o)
);

// File: tb/retstk_ctrl_bench.sv
module retstk_ctrl_bench;
   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic        rst, call, irq, ret, reti;
   logic [12:0] pc;
   logic [2:0]  fl;
   logic [7:0]  ram_addr, ram_wdata, ram_rdata;
   logic        ram_we, ram_re;
   logic [12:0] rest_pc;
   logic [2:0]  rest_flags;
   logic        rest_valid, flag_load, busy;
   logic [7:0]  sp;

   retstk_ctrl u_retstk_ctrl (
      .clk(clk), .rst(rst), .call_i(call), .irq_i(irq), .ret_i(ret), .reti_i(reti),
      .pc_i(pc), .flags_i(fl), .ram_addr_o(ram_addr), .ram_we_o(ram_we),
      .ram_re_o(ram_re), .ram_wdata_o(ram_wdata), .ram_rdata_i(ram_rdata),
      .rest_pc_o(rest_pc), .rest_flags_o(rest_flags), .rest_valid_o(rest_valid),
      .flag_load_o(flag_load), .sp_o(sp), .busy_o(busy)
   );

   logic [7:0] mem [256];
   always @(posedge clk) if (ram_we) mem[ram_addr] <= ram_wdata;
   assign ram_rdata = mem[ram_addr];

   int n_chk = 0;
   int n_fail = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   typedef struct packed { logic [12:0] pc; logic [2:0] fl; } lvl_t;
   typedef struct packed { logic [12:0] pc; logic [2:0] fl; logic ld; } res_t;
   lvl_t stk_q[$];
   res_t exp_q[$];
   res_t mon_e;
   logic [7:0] exp_sp;

   // scoreboard monitor
   always @(negedge clk) begin
      if (!rst && rest_valid) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R5 unexpected restore pulse", 1, 0);
         end else begin
            mon_e = exp_q.pop_front();
            chk(rest_pc == mon_e.pc, "R5 restored pc", int'(rest_pc), int'(mon_e.pc));
            chk(rest_flags == mon_e.fl, "R5 restored flags", int'(rest_flags), int'(mon_e.fl));
            chk(flag_load == mon_e.ld, "R6 flag_load", int'(flag_load), int'(mon_e.ld));
         end
      end
   end

   task automatic strobe(input bit c, input bit i, input bit r, input bit ri,
                         input logic [12:0] p, input logic [2:0] f);
      @(negedge clk);
      call = c; irq = i; ret = r; reti = ri; pc = p; fl = f;
      @(negedge clk);
      call = 0; irq = 0; ret = 0; reti = 0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1;
      repeat (2) @(negedge clk);
      rst = 0;
      stk_q.delete();
      exp_sp = 8'hFF;
   endtask

   task automatic do_push(input logic [12:0] p, input logic [2:0] f, input bit is_irq);
      strobe(!is_irq, is_irq, 0, 0, p, f);
      chk(busy == 1'b1, "R8 busy first push cycle", int'(busy), 1);
      @(negedge clk);
      chk(busy == 1'b1, "R8 busy second push cycle", int'(busy), 1);
      @(negedge clk);
      chk(busy == 1'b0, "R8 idle after push", int'(busy), 0);
      chk(mem[exp_sp] == p[7:0], "R2 low byte at sp", int'(mem[exp_sp]), int'(p[7:0]));
      chk(mem[8'(exp_sp - 1)] == {f, p[12:8]}, "R2 high byte at sp-1",
          int'(mem[8'(exp_sp - 1)]), int'({f, p[12:8]}));
      stk_q.push_back('{pc: p, fl: f});
      exp_sp = exp_sp - 8'd2;
      chk(sp == exp_sp, "R3 sp after push", int'(sp), int'(exp_sp));
   endtask

   task automatic do_pop(input bit is_reti);
      lvl_t l;
      l = stk_q.pop_back();
      exp_q.push_back('{pc: l.pc, fl: l.fl, ld: is_reti});
      strobe(0, 0, !is_reti, is_reti, 13'h0, 3'h0);
      chk(busy == 1'b1, "R8 busy first pop cycle", int'(busy), 1);
      @(negedge clk);
      @(negedge clk);
      chk(rest_valid == 1'b1, "R5 restore pulse present", int'(rest_valid), 1);
      exp_sp = exp_sp + 8'd2;
      chk(sp == exp_sp, "R4 sp after pop", int'(sp), int'(exp_sp));
      @(negedge clk);
      chk(rest_valid == 1'b0, "R5 pulse one cycle", int'(rest_valid), 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      chk(1'b0, "watchdog expired", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      for (int a = 0; a < 256; a++) mem[a] = 8'h00;
      rst = 1; call = 0; irq = 0; ret = 0; reti = 0; pc = '0; fl = '0;
      exp_sp = 8'hFF;
      do_reset();
      // R1 reset state
      chk(sp == 8'hFF, "R1 sp reset", int'(sp), 255);
      chk(busy == 1'b0, "R1 busy reset", int'(busy), 0);
      chk(rest_valid == 1'b0 && flag_load == 1'b0, "R1 valid/flag_load reset",
          int'({rest_valid, flag_load}), 0);
      chk(rest_pc == 13'h0 && rest_flags == 3'h0, "R1 restore regs reset",
          int'({rest_pc, rest_flags}), 0);

      // push via call and interrupt, then pop in reverse with both return kinds
      do_push(13'h1ABC, 3'b101, 1'b0);
      do_push(13'h0123, 3'b010, 1'b1);
      do_pop(1'b1);   // R6 interrupt return reloads flags
      do_pop(1'b0);   // R6 subroutine return keeps flags

      // R7 push wins over simultaneous return
      strobe(1, 0, 1, 0, 13'h0777, 3'b001);
      @(negedge clk);
      @(negedge clk);
      chk(sp == 8'hFD, "R7 push taken on collision", int'(sp), 253);
      chk(mem[8'hFF] == 8'h77, "R7 low byte written", int'(mem[8'hFF]), 'h77);
      stk_q.push_back('{pc: 13'h0777, fl: 3'b001});
      exp_sp = 8'hFD;

      // R8 return strobe during a push is ignored
      strobe(1, 0, 0, 0, 13'h0F0F, 3'b110);
      ret = 1;
      @(negedge clk);
      ret = 0;
      @(negedge clk);
      chk(sp == 8'hFB, "R8 strobe ignored while busy", int'(sp), 251);
      chk(rest_valid == 1'b0, "R8 no restore from ignored strobe", int'(rest_valid), 0);
      stk_q.push_back('{pc: 13'h0F0F, fl: 3'b110});
      exp_sp = 8'hFB;
      do_pop(1'b0);
      do_pop(1'b1);

      // R3 wrap: 128 levels fill the RAM, the next overwrites the oldest
      do_reset();
      for (int i = 0; i < 128; i++) do_push(13'(i * 37 + 5), 3'(i), i[0]);
      chk(sp == 8'hFF, "R3 sp wraps after 128 levels", int'(sp), 255);
      do_push(13'h1555, 3'b011, 1'b0);
      chk(mem[8'hFF] == 8'h55, "R3 oldest level overwritten", int'(mem[8'hFF]), 'h55);
      do_pop(1'b1);

      repeat (3) @(negedge clk);
      chk(exp_q.size() == 0, "R5 every expected restore seen", exp_q.size(), 0);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule